// File: doc/BRIEF.md
# Encoded-Interval Watchdog Timer

This block is a watchdog timer set up through a single 8-bit control register. The low two bits pick a resolution, the next five bits hold a multiplier and the top bit steers the outcome of a timeout. The block counts down on a one-cycle tick input that pulses sixteen times a second. The timeout is the multiplier times four raised to the resolution, in ticks.

Software restarts the countdown by writing a new value or by reading the stored one. Every restart clears a watchdog flag output, and a timeout sets it. With the steering bit set, a timeout raises a one-cycle reset request, raises a one-cycle strobe that clears an external century bit, and clears the control register. With the steering bit clear, a timeout raises a single interrupt pulse and leaves the register as it was. In either case the countdown stops after a timeout until the next restart.

Top module: `wdt_encoded`

## Requirements
- R1: The control register's bits 1:0 hold resolution R, bits 6:2 hold multiplier M and bit 7 is the steering bit. The timeout comes on the (4^R)*M-th tick after a restart.
- R2: A stored value of zero, or any value whose multiplier M is zero, disables the timer and no timeout occurs.
- R3: A write strobe stores wr_data, and rd_data shows the stored value from the next cycle. The write restarts the countdown with the new value.
- R4: A read strobe restarts the countdown with the value already stored.
- R5: Every restart clears wd_flag. A timeout sets wd_flag, and it stays set until the next restart.
- R6: A timeout with bit 7 set pulses rst_req and century_clr high together for exactly one cycle and clears the control register to zero, so no further timeout follows.
- R7: A timeout with bit 7 clear pulses irq_pulse high for exactly one cycle and keeps the register value. No further timeout follows until a restart.
- R8: The synchronous reset clears the register, stops the countdown and drives wd_flag, rst_req, irq_pulse and century_clr low.
- R9: A restart in the same cycle as the final tick wins: no timeout happens, and the new interval starts from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse at 16 Hz |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (restarts the timer) |
| wr_data | input | 8 | Value to write |
| rd_data | output | 8 | Stored control register |
| wd_flag | output | 1 | Watchdog timeout flag |
| rst_req | output | 1 | One-cycle reset request |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| century_clr | output | 1 | One-cycle clear strobe for the external century bit |

## Verification
The hardest case to reach from the ports is a restart strobe that lands in the same clock cycle as the tick that would expire the count. The bench arms a one-tick interval, then raises the tick and a write strobe in one cycle. It confirms that no flag or pulse appears and that the new interval runs in full. A read restart in the middle of a count is placed between single ticks in the same way. The longest interval, 1984 ticks, is also run to completion to exercise the full counter width.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Outcome selected by the top control bit at timeout
  typedef enum logic {
    STEER_IRQ = 1'b0,
    STEER_RST = 1'b1
  } steer_e;
endpackage

// File: rtl/wdt_decode.sv
module wdt_decode #(
  parameter int RES_W = 2,
  parameter int MUL_W = 5,
  parameter int CNT_W = 11
) (
  input  logic [RES_W-1:0] res,
  input  logic [MUL_W-1:0] mul,
  output logic [CNT_W-1:0] interval
);
  localparam int PAD_W = CNT_W - MUL_W;

  // interval = mul * 4^res, a shift by twice the resolution
  always_comb begin
    interval = {{PAD_W{1'b0}}, mul} << {res, 1'b0};
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (tick && count_q != '0) begin
      count_q <= count_q - 1'b1;
    end
  end

  assign expire = tick && !load && (count_q == CNT_W'(1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0 && !load) |=> (count_q == '0));
endmodule

// File: rtl/wdt_encoded.sv
module wdt_encoded #(
  parameter int RES_W  = 2,
  parameter int MUL_W  = 5,
  parameter int DATA_W = RES_W + MUL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wd_flag,
  output logic              rst_req,
  output logic              irq_pulse,
  output logic              century_clr
);
  import wdt_pkg::*;

  localparam int CNT_W  = 2 * ((1 << RES_W) - 1) + MUL_W;
  localparam int STEER  = DATA_W - 1;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] src_val;
  logic [CNT_W-1:0]  interval;
  logic              restart;
  logic              expire;
  steer_e            steer;

  assign restart = wr_en | rd_en;
  assign src_val = wr_en ? wr_data : ctrl_q;
  assign steer   = steer_e'(ctrl_q[STEER]);

  wdt_decode #(.RES_W(RES_W), .MUL_W(MUL_W), .CNT_W(CNT_W)) u_decode (
    .res      (src_val[RES_W-1:0]),
    .mul      (src_val[RES_W+MUL_W-1:RES_W]),
    .interval (interval)
  );

  wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (restart),
    .load_val (interval),
    .tick     (tick),
    .expire   (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      wd_flag     <= 1'b0;
      rst_req     <= 1'b0;
      irq_pulse   <= 1'b0;
      century_clr <= 1'b0;
    end else begin
      rst_req     <= 1'b0;
      irq_pulse   <= 1'b0;
      century_clr <= 1'b0;
      if (wr_en) ctrl_q <= wr_data;
      if (restart) begin
        wd_flag <= 1'b0;
      end else if (expire) begin
        wd_flag <= 1'b1;
        if (steer == STEER_RST) begin
          rst_req     <= 1'b1;
          century_clr <= 1'b1;
          ctrl_q      <= '0;
        end else begin
          irq_pulse <= 1'b1;
        end
      end
    end
  end

  assign rd_data = ctrl_q;

  // R6
  steer_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (century_clr && ctrl_q == '0));
  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);
  // R6
  rst_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  // R7
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_pulse && rst_req));
  // R5
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_flag) |-> (irq_pulse || rst_req));
  // R3
  write_restart_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!wd_flag && ctrl_q == $past(wr_data)));
endmodule

// File: tb/wdt_encoded_tb.sv
module wdt_encoded_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       wd_flag, rst_req, irq_pulse, century_clr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_encoded u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .wd_flag(wd_flag),
    .rst_req(rst_req), .irq_pulse(irq_pulse), .century_clr(century_clr)
  );

  // value, expected tick count of the timeout (0 = none)
  localparam int NV = 10;
  localparam logic [7:0] VEC_VAL [NV] = '{8'h04, 8'h05, 8'h08, 8'h0E, 8'h7C,
                                          8'h00, 8'h03, 8'h89, 8'h8C, 8'h7F};
  localparam int VEC_EXP [NV] = '{1, 4, 2, 48, 31, 0, 0, 8, 3, 1984};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // one tick; outputs sampled at the negedge after the counting edge
  task automatic give_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  // ticks until the flag rises or the limit runs out; returns tick count or 0
  task automatic run_ticks(input int limit, output int hit, output bit saw_irq,
                           output bit saw_rst, output bit saw_clr);
    hit = 0; saw_irq = 0; saw_rst = 0; saw_clr = 0;
    for (int n = 1; n <= limit; n++) begin
      give_tick();
      if (wd_flag) begin
        hit = n; saw_irq = irq_pulse; saw_rst = rst_req; saw_clr = century_clr;
        break;
      end
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hit; bit si, sr, sc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(rd_data == 8'h00 && !wd_flag && !rst_req && !irq_pulse && !century_clr,
        "R8 reset state", {rd_data, wd_flag}, 0);

    // R1 R2 R3 R6 R7 vector walk
    for (int i = 0; i < NV; i++) begin
      do_write(VEC_VAL[i]);
      chk(rd_data == VEC_VAL[i] && !wd_flag, "R3 readback/flag clear", rd_data, VEC_VAL[i]);
      run_ticks((VEC_EXP[i] == 0) ? 80 : VEC_EXP[i] + 2, hit, si, sr, sc);
      chk(hit == VEC_EXP[i], (VEC_EXP[i] == 0) ? "R2 disabled" : "R1 interval", hit, VEC_EXP[i]);
      if (VEC_EXP[i] != 0) begin
        if (VEC_VAL[i][7]) begin
          chk(sr && sc && !si, "R6 reset request", {si, sr, sc}, 3'b011);
          chk(rd_data == 8'h00, "R6 register cleared", rd_data, 0);
        end else begin
          chk(si && !sr && !sc, "R7 interrupt pulse", {si, sr, sc}, 3'b100);
          chk(rd_data == VEC_VAL[i], "R7 register kept", rd_data, VEC_VAL[i]);
        end
        @(negedge clk);
        chk(!irq_pulse && !rst_req && !century_clr && wd_flag, "R5 R6 R7 single pulse, flag held",
            {irq_pulse, rst_req, century_clr, wd_flag}, 4'b0001);
        run_ticks(20, hit, si, sr, sc);
        chk(!irq_pulse && !rst_req, "R7 no repeat after timeout", {irq_pulse, rst_req}, 0);
      end
    end

    // R4 read restarts with stored value, and clears the flag
    do_write(8'h08);
    give_tick();
    do_read();
    give_tick();
    chk(!wd_flag, "R4 read restart delays timeout", wd_flag, 0);
    give_tick();
    chk(wd_flag && irq_pulse, "R4 timeout after read restart", {wd_flag, irq_pulse}, 2'b11);
    do_read();
    chk(!wd_flag && rd_data == 8'h08, "R5 read clears flag", {wd_flag, rd_data}, 9'h008);
    run_ticks(5, hit, si, sr, sc);
    chk(hit == 2, "R4 read re-arms stored interval", hit, 2);

    // R9 restart in the final-tick cycle wins
    do_write(8'h04);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_data = 8'h08;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    chk(!wd_flag && !irq_pulse, "R9 no timeout on restart cycle", {wd_flag, irq_pulse}, 0);
    run_ticks(5, hit, si, sr, sc);
    chk(hit == 2 && si, "R9 new interval runs in full", hit, 2);

    // R8 reset mid-count
    do_write(8'h88);
    give_tick();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(rd_data == 8'h00 && !wd_flag, "R8 reset clears register", rd_data, 0);
    run_ticks(20, hit, si, sr, sc);
    chk(hit == 0 && !rst_req && !century_clr, "R8 countdown stopped", hit, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule